// File: doc/BRIEF.md
# Deferred Write Buffer Retire Controller

This block holds one pending write for a memory device on a shared command channel. A write command addressed to this device loads the buffer with one dualoct of data, a per-byte mask, and the bank and column the data belongs to. The data is not committed to the sense-amp array in that slot. The entry is handed to the array later, during a column-command slot that allows it.

Every column slot carries an opcode and a 5-bit target device ID. The block compares that ID with the local ID and decides whether the pending entry may retire in that slot. The one forbidden case is a read aimed at this device. A retire shows up one cycle after the qualifying slot. It is a single-cycle strobe that carries the stored bank, column and data, plus byte enables derived from the mask. The array, packet decoding and precharge sequencing are outside this block. The precharge forms of the commands follow the same retire rules as their plain forms.

Top module: `wbr_top`

## Requirements
- R1: A write (code 2) or write-with-precharge (code 5) whose target ID equals `my_id` loads data, mask, bank and column, and `buf_full` is high after that clock edge.
- R2: A load into an empty buffer produces no retire strobe from that same slot, because `ret_vld` stays low in the following cycle.
- R3: While an entry is pending, a read (code 3), write (code 2) or no-op column command (code 1) aimed at another ID makes `ret_vld` high for one cycle after that edge. That cycle carries the stored bank, column and data, and `buf_full` drops. A write aimed at another ID never loads the buffer.
- R4: While an entry is pending, a no-op column command or a write aimed at `my_id` retires the entry with the same timing as R3.
- R5: A read (code 3) or read-with-precharge (code 6) aimed at `my_id` never retires. `buf_full` stays high and `ret_vld` stays low.
- R6: `ret_be` bit i is the inverse of stored mask bit i, and it governs `ret_data` bits [8i+7:8i]. A mask bit of 1 suppresses that byte.
- R7: A write to `my_id` arriving while an entry is pending retires the old entry and loads the new one at the same edge. `buf_full` stays high.
- R8: The precharge forms, codes 4 (no-op with precharge), 5 and 6, obey the same retire and load rules as codes 1, 2 and 3.
- R9: Synchronous active-high reset empties the buffer and holds `ret_vld` low. After reset, a qualifying slot produces no retire.
- R10: An idle slot (code 0) or the unused code 7 neither retires nor loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 5 | Local device ID |
| cmd_op | input | 3 | Column slot opcode (0 idle, 1 no-op, 2 write, 3 read, 4 no-op+precharge, 5 write+precharge, 6 read+precharge) |
| cmd_id | input | 5 | Target device ID of the slot |
| wr_data | input | 8*BYTES | Write data for a loading write |
| wr_mask | input | BYTES | Byte mask, 1 suppresses the byte |
| wr_bank | input | BANK_W | Bank address of the write |
| wr_col | input | COL_W | Column address of the write |
| ret_vld | output | 1 | Retire strobe |
| ret_bank | output | BANK_W | Bank of the retiring entry |
| ret_col | output | COL_W | Column of the retiring entry |
| ret_data | output | 8*BYTES | Data of the retiring entry |
| ret_be | output | BYTES | Byte enables of the retiring entry |
| buf_full | output | 1 | An entry is pending |

## Verification
The bench builds the block with BYTES set to 4, BANK_W at its default of 5 and COL_W at its default of 7. At those widths every mask pattern of interest fits in a short vector table, and the extreme bank and column addresses 31 and 127 can be reached directly. With a narrow data path, the byte-to-enable mapping can be read lane by lane in each retired word. This makes a swapped or inverted lane show up at once, next to the same-device read hold and the back-to-back write replacement.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int DEVID_W = 5;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_NOCOP  = 3'd1,
        OP_WR     = 3'd2,
        OP_RD     = 3'd3,
        OP_NOCOPP = 3'd4,
        OP_WRP    = 3'd5,
        OP_RDP    = 3'd6,
        OP_UNUSED = 3'd7
    } col_op_e;

    function automatic logic op_is_read(col_op_e op);
        return (op == OP_RD) || (op == OP_RDP);
    endfunction

    function automatic logic op_is_write(col_op_e op);
        return (op == OP_WR) || (op == OP_WRP);
    endfunction

    function automatic logic op_is_slot(col_op_e op);
        return (op != OP_IDLE) && (op != OP_UNUSED);
    endfunction

endpackage

// File: rtl/wbr_retire_qual.sv
module wbr_retire_qual
    import wbr_pkg::*;
(
    input  col_op_e             op,
    input  logic [DEVID_W-1:0]  cmd_id,
    input  logic [DEVID_W-1:0]  my_id,
    input  logic                pending,
    output logic                retire,
    output logic                load
);
    logic hit;

    always_comb begin
        hit    = (cmd_id == my_id);
        retire = pending && op_is_slot(op) && !(op_is_read(op) && hit);
        load   = op_is_write(op) && hit;
    end
endmodule

// File: rtl/wbr_entry_reg.sv
module wbr_entry_reg #(
    parameter int BYTES  = 16,
    parameter int BANK_W = 5,
    parameter int COL_W  = 7,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              retire,
    input  logic [DATA_W-1:0] d_data,
    input  logic [BYTES-1:0]  d_mask,
    input  logic [BANK_W-1:0] d_bank,
    input  logic [COL_W-1:0]  d_col,
    output logic [DATA_W-1:0] q_data,
    output logic [BYTES-1:0]  q_mask,
    output logic [BANK_W-1:0] q_bank,
    output logic [COL_W-1:0]  q_col,
    output logic              pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            q_data  <= '0;
            q_mask  <= '0;
            q_bank  <= '0;
            q_col   <= '0;
        end else if (load) begin
            pending <= 1'b1;
            q_data  <= d_data;
            q_mask  <= d_mask;
            q_bank  <= d_bank;
            q_col   <= d_col;
        end else if (retire) begin
            pending <= 1'b0;
        end
    end

    // R5: with neither load nor retire, the pending state and entry hold
    p_hold_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && !retire) |=> ($stable(pending) && $stable(q_data) && $stable(q_mask)));

    // R1: a load always leaves an entry pending
    p_load_pending_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> pending);
endmodule

// File: rtl/wbr_retire_out.sv
module wbr_retire_out #(
    parameter int BYTES  = 16,
    parameter int BANK_W = 5,
    parameter int COL_W  = 7,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retire,
    input  logic [DATA_W-1:0] e_data,
    input  logic [BYTES-1:0]  e_mask,
    input  logic [BANK_W-1:0] e_bank,
    input  logic [COL_W-1:0]  e_col,
    output logic              ret_vld,
    output logic [DATA_W-1:0] ret_data,
    output logic [BYTES-1:0]  ret_be,
    output logic [BANK_W-1:0] ret_bank,
    output logic [COL_W-1:0]  ret_col
);
    logic [BYTES-1:0] be_next;

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign be_next[i] = ~e_mask[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_vld  <= 1'b0;
            ret_data <= '0;
            ret_be   <= '0;
            ret_bank <= '0;
            ret_col  <= '0;
        end else begin
            ret_vld <= retire;
            if (retire) begin
                ret_data <= e_data;
                ret_be   <= be_next;
                ret_bank <= e_bank;
                ret_col  <= e_col;
            end
        end
    end

    // R6: enables are the inverse of the mask seen at the retiring slot
    p_be_inverse_r6: assert property (@(posedge clk) disable iff (rst)
        retire |=> (ret_be == ~$past(e_mask)));
endmodule

// File: rtl/wbr_top.sv
module wbr_top
    import wbr_pkg::*;
#(
    parameter int BYTES  = 16,
    parameter int BANK_W = 5,
    parameter int COL_W  = 7,
    localparam int DATA_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        my_id,
    input  logic [2:0]        cmd_op,
    input  logic [4:0]        cmd_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_mask,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    output logic              ret_vld,
    output logic [BANK_W-1:0] ret_bank,
    output logic [COL_W-1:0]  ret_col,
    output logic [DATA_W-1:0] ret_data,
    output logic [BYTES-1:0]  ret_be,
    output logic              buf_full
);
    col_op_e          op;
    logic             retire;
    logic             load;
    logic [DATA_W-1:0] e_data;
    logic [BYTES-1:0]  e_mask;
    logic [BANK_W-1:0] e_bank;
    logic [COL_W-1:0]  e_col;

    assign op = col_op_e'(cmd_op);

    wbr_retire_qual u_qual (
        .op      (op),
        .cmd_id  (cmd_id),
        .my_id   (my_id),
        .pending (buf_full),
        .retire  (retire),
        .load    (load)
    );

    wbr_entry_reg #(.BYTES(BYTES), .BANK_W(BANK_W), .COL_W(COL_W)) u_entry (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .retire  (retire),
        .d_data  (wr_data),
        .d_mask  (wr_mask),
        .d_bank  (wr_bank),
        .d_col   (wr_col),
        .q_data  (e_data),
        .q_mask  (e_mask),
        .q_bank  (e_bank),
        .q_col   (e_col),
        .pending (buf_full)
    );

    wbr_retire_out #(.BYTES(BYTES), .BANK_W(BANK_W), .COL_W(COL_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .retire   (retire),
        .e_data   (e_data),
        .e_mask   (e_mask),
        .e_bank   (e_bank),
        .e_col    (e_col),
        .ret_vld  (ret_vld),
        .ret_data (ret_data),
        .ret_be   (ret_be),
        .ret_bank (ret_bank),
        .ret_col  (ret_col)
    );

    // R5 and R8: a read of either form to this device never produces a retire
    p_no_self_read_retire_r5: assert property (@(posedge clk) disable iff (rst)
        ((cmd_op == 3'd3 || cmd_op == 3'd6) && cmd_id == my_id) |=> !ret_vld);

    // R2: nothing can retire from an empty buffer
    p_empty_no_retire_r2: assert property (@(posedge clk) disable iff (rst)
        !buf_full |=> !ret_vld);

    // R10: idle and unused codes never strobe
    p_idle_no_retire_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 3'd0 || cmd_op == 3'd7) |=> !ret_vld);

    // R3: a non-read slot to another device with an entry pending retires it
    p_foreign_retire_r3: assert property (@(posedge clk) disable iff (rst)
        (buf_full && cmd_id != my_id && cmd_op != 3'd0 && cmd_op != 3'd7) |=> ret_vld);

    // R9: reset leaves the buffer empty and the strobe low
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!ret_vld && !buf_full));
endmodule

// File: tb/wbr_top_test.sv
module wbr_top_test;
    localparam int BYTES  = 4;
    localparam int BANK_W = 5;
    localparam int COL_W  = 7;
    localparam int DW     = 8 * BYTES;
    localparam logic [4:0] ME = 5'd9;

    typedef struct packed {
        logic [2:0]        op;
        logic [4:0]        id;
        logic [DW-1:0]     d;
        logic [BYTES-1:0]  m;
        logic [BANK_W-1:0] b;
        logic [COL_W-1:0]  c;
        logic              ev;
        logic              ef;
        logic [DW-1:0]     ed;
        logic [BYTES-1:0]  ebe;
        logic [BANK_W-1:0] eb;
        logic [COL_W-1:0]  ec;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{3'd2, 5'd9, 32'hA1A2A3A4, 4'h0, 5'd3,  7'd10,  1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd2},         // R1 R2
        '{3'd3, 5'd9, 32'h0, 4'h0, 5'd0, 7'd0,           1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd5},         // R5
        '{3'd6, 5'd9, 32'h0, 4'h0, 5'd0, 7'd0,           1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd8},         // R8 R5
        '{3'd0, 5'd2, 32'h0, 4'h0, 5'd0, 7'd0,           1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd10},        // R10
        '{3'd3, 5'd2, 32'h0, 4'h0, 5'd0, 7'd0,           1'b1, 1'b0, 32'hA1A2A3A4, 4'hF, 5'd3, 7'd10, 4'd3}, // R3
        '{3'd2, 5'd2, 32'h99999999, 4'h0, 5'd8, 7'd8,    1'b0, 1'b0, 32'h0, 4'h0, 5'd0, 7'd0, 4'd3},         // R3
        '{3'd2, 5'd9, 32'h11223344, 4'h5, 5'd7, 7'd0,    1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd1},         // R1
        '{3'd2, 5'd9, 32'h55667788, 4'h8, 5'd31, 7'd127, 1'b1, 1'b1, 32'h11223344, 4'hA, 5'd7, 7'd0, 4'd7},  // R7 R6
        '{3'd1, 5'd9, 32'h0, 4'h0, 5'd0, 7'd0,           1'b1, 1'b0, 32'h55667788, 4'h7, 5'd31, 7'd127, 4'd4}, // R4 R6
        '{3'd5, 5'd9, 32'hCAFEBABE, 4'h0, 5'd1, 7'd1,    1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd8},         // R8
        '{3'd4, 5'd9, 32'h0, 4'h0, 5'd0, 7'd0,           1'b1, 1'b0, 32'hCAFEBABE, 4'hF, 5'd1, 7'd1, 4'd8},  // R8 R4
        '{3'd5, 5'd4, 32'h12345678, 4'h0, 5'd9, 7'd9,    1'b0, 1'b0, 32'h0, 4'h0, 5'd0, 7'd0, 4'd8},         // R8
        '{3'd2, 5'd9, 32'hDEADBEEF, 4'hF, 5'd2, 7'd5,    1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd1},         // R1
        '{3'd7, 5'd3, 32'h0, 4'h0, 5'd0, 7'd0,           1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd10},        // R10
        '{3'd2, 5'd4, 32'h0, 4'h0, 5'd0, 7'd0,           1'b1, 1'b0, 32'hDEADBEEF, 4'h0, 5'd2, 7'd5, 4'd3},  // R3 R6
        '{3'd2, 5'd9, 32'h01020304, 4'h2, 5'd6, 7'd6,    1'b0, 1'b1, 32'h0, 4'h0, 5'd0, 7'd0, 4'd1},         // R1
        '{3'd6, 5'd0, 32'h0, 4'h0, 5'd0, 7'd0,           1'b1, 1'b0, 32'h01020304, 4'hD, 5'd6, 7'd6, 4'd8}   // R8 R6
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        my_id = ME;
    logic [2:0]        cmd_op = 3'd0;
    logic [4:0]        cmd_id = 5'd0;
    logic [DW-1:0]     wr_data = '0;
    logic [BYTES-1:0]  wr_mask = '0;
    logic [BANK_W-1:0] wr_bank = '0;
    logic [COL_W-1:0]  wr_col = '0;
    logic              ret_vld;
    logic [BANK_W-1:0] ret_bank;
    logic [COL_W-1:0]  ret_col;
    logic [DW-1:0]     ret_data;
    logic [BYTES-1:0]  ret_be;
    logic              buf_full;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    wbr_top #(.BYTES(BYTES), .BANK_W(BANK_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst(rst), .my_id(my_id), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .wr_data(wr_data), .wr_mask(wr_mask), .wr_bank(wr_bank), .wr_col(wr_col),
        .ret_vld(ret_vld), .ret_bank(ret_bank), .ret_col(ret_col),
        .ret_data(ret_data), .ret_be(ret_be), .buf_full(buf_full)
    );

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [4:0] id, input logic [DW-1:0] d,
                         input logic [BYTES-1:0] m, input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c);
        cmd_op = op; cmd_id = id; wr_data = d; wr_mask = m; wr_bank = b; wr_col = c;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("reset ret_vld", 9, 32'(ret_vld), 32'd0);   // R9
        chk("reset buf_full", 9, 32'(buf_full), 32'd0); // R9
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(TBL[k].op, TBL[k].id, TBL[k].d, TBL[k].m, TBL[k].b, TBL[k].c);
            @(posedge clk);
            #2;
            chk($sformatf("row %0d ret_vld", k), int'(TBL[k].req), 32'(ret_vld), 32'(TBL[k].ev));
            chk($sformatf("row %0d buf_full", k), int'(TBL[k].req), 32'(buf_full), 32'(TBL[k].ef));
            if (TBL[k].ev) begin
                chk($sformatf("row %0d data", k), int'(TBL[k].req), ret_data, TBL[k].ed);
                chk($sformatf("row %0d be", k), int'(TBL[k].req), 32'(ret_be), 32'(TBL[k].ebe));
                chk($sformatf("row %0d bank", k), int'(TBL[k].req), 32'(ret_bank), 32'(TBL[k].eb));
                chk($sformatf("row %0d col", k), int'(TBL[k].req), 32'(ret_col), 32'(TBL[k].ec));
            end
        end

        // R9: reset while an entry is pending discards it
        @(negedge clk);
        drive(3'd2, ME, 32'h77777777, 4'h0, 5'd4, 7'd4);
        @(posedge clk); #2;
        chk("preload full", 1, 32'(buf_full), 32'd1);
        @(negedge clk);
        drive(3'd0, 5'd0, '0, '0, '0, '0);
        rst = 1'b1;
        @(posedge clk); #2;
        chk("mid reset buf_full", 9, 32'(buf_full), 32'd0);
        chk("mid reset ret_vld", 9, 32'(ret_vld), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(3'd1, 5'd3, '0, '0, '0, '0);
        @(posedge clk); #2;
        chk("post reset no retire", 9, 32'(ret_vld), 32'd0); // R9

        // R2: a pulse lasts one cycle and an idle slot after it is quiet
        @(negedge clk);
        drive(3'd2, ME, 32'h0BADF00D, 4'h3, 5'd5, 7'd64);
        @(posedge clk); #2;
        chk("load no strobe", 2, 32'(ret_vld), 32'd0);
        @(negedge clk);
        drive(3'd1, 5'd1, '0, '0, '0, '0);
        @(posedge clk); #2;
        chk("retire strobe", 3, 32'(ret_vld), 32'd1);
        chk("retire be", 6, 32'(ret_be), 32'hC);
        @(negedge clk);
        drive(3'd0, 5'd0, '0, '0, '0, '0);
        @(posedge clk); #2;
        chk("strobe one cycle", 3, 32'(ret_vld), 32'd0);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule